// File: doc/BRIEF.md
# Fine-Pulse 14-bit PWM DAC Timer

This block turns a 14-bit code into a single PWM bit stream whose average high time over one conversion period of 16384 clock cycles equals the code. A free-running 14-bit counter is split into a position inside a base cycle and the index of that base cycle. The upper part of the code sets a coarse pulse at the start of every base cycle. The lower part adds a one-clock extension to some base cycles, and these are spread evenly by comparing the fine bits with the bit-reversed base-cycle index. A carrier bit picks a 64-clock or a 256-clock base cycle, and so also decides how the code splits into coarse and fine parts.

Software reaches the block through a two-address register bus. A select flag, visible as bit 0 at address 0 in both views, maps address 0 to the data register or the control register, and address 1 to a spare data holding register or the counter. A code too small for the chosen carrier gives no coarse pulse and holds the output low. A new code or carrier value is picked up only at a base-cycle boundary, so no runt pulses appear.

Top module: `pwm_dac14`

## Requirements
- R1: After reset, the data register is 0xFFFF (code 0x3FFF, carrier bit 1, select 1), the enable is 0, the counter is 0 and the output is low. Address 0 then reads the control view, which is 0x0001.
- R2: With select 0, address 0 is the data register and address 1 is a 16-bit holding register that has no effect on the output. With select 1, address 0 is the control register and address 1 is the counter, read as 14 bits zero-extended to 16.
- R3: While enabled, the counter increments by one every clock and wraps from 0x3FFF to 0. A write to the counter view loads bits 13:0 and takes priority over the increment. While disabled, the counter holds 0 and writes to it are ignored.
- R4: With carrier bit 0, a base cycle is 64 clocks, and the coarse pulse is high for code[13:8] clocks at the start of the cycle. Base cycle i gets one extra clock when the 8-bit bit-reversal of i is below code[7:0].
- R5: With carrier bit 1, a base cycle is 256 clocks. The coarse width is code[13:6], and base cycle i gets one extra clock when the 6-bit bit-reversal of i is below code[5:0].
- R6: For an in-range code, the number of high output clocks in any 16384 consecutive clocks of steady operation equals the code, for both carrier settings.
- R7: A code whose coarse field is zero is out of range: below 0x100 with carrier bit 0, or below 0x40 with carrier bit 1. Such a code holds the output low.
- R8: A code or carrier written during a base cycle takes effect only from the next base-cycle start. The rest of the current cycle keeps the old pulse pattern.
- R9: While the enable is 0, the output is low.
- R10: Field layout: data register bits 15:2 hold the code, bit 1 the carrier bit and bit 0 the select. Control register bit 1 is the enable and bit 0 is the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address (0 or 1) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| pwm_o | output | 1 | PWM output, registered |

## Verification
A bus write can land at any point of a running base cycle, while the waveform logic is generating a pulse from the code it latched at the last boundary. The bench forces this collision. It polls the counter until the position is mid-cycle, then rewrites the code from a small coarse width to a large one. The remaining clocks of that cycle must show no high output, and the following cycle must show exactly the new width. A second overlap is a counter load in the same clock as the increment, which is judged by reading the loaded value and its successors across the wrap.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  localparam int DATA_W      = 14;
  localparam int REG_W       = DATA_W + 2;
  localparam int FINE_W_FAST = 8;   // 64-clock base cycle
  localparam int FINE_W_SLOW = 6;   // 256-clock base cycle
  localparam int CTRL_EN_BIT = 1;
  localparam int N_CARRIER   = 2;
endpackage

// File: rtl/pwm_dac_regs.sv
module pwm_dac_regs
  import pwm_dac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [DATA_W-1:0] data_o,
  output logic              cfs_o,
  output logic              en_o,
  output logic              cnt_ld_o
);
  logic [DATA_W-1:0] data_q;
  logic [REG_W-1:0]  aux_q;
  logic cfs_q, regs_q, en_q;
  logic wr0, wr1;

  assign wr0 = wr_i && !addr_i;
  assign wr1 = wr_i &&  addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '1;
      cfs_q  <= 1'b1;
      regs_q <= 1'b1;
      en_q   <= 1'b0;
      aux_q  <= '1;
    end else begin
      if (wr0) begin
        if (!regs_q) begin
          data_q <= wdata_i[REG_W-1:2];
          cfs_q  <= wdata_i[1];
          regs_q <= wdata_i[0];
        end else begin
          en_q   <= wdata_i[CTRL_EN_BIT];
          regs_q <= wdata_i[0];
        end
      end
      if (wr1 && !regs_q) aux_q <= wdata_i;
    end
  end

  always_comb begin
    case ({addr_i, regs_q})
      2'b00:   rdata_o = {data_q, cfs_q, regs_q};
      2'b01:   rdata_o = {{(REG_W-2){1'b0}}, en_q, regs_q};
      2'b10:   rdata_o = aux_q;
      default: rdata_o = REG_W'(cnt_i);
    endcase
  end

  assign data_o   = data_q;
  assign cfs_o    = cfs_q;
  assign en_o     = en_q;
  assign cnt_ld_o = wr1 && regs_q;

  // R10
  data_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 && !regs_q |=> data_o == $past(wdata_i[REG_W-1:2]) && cfs_o == $past(wdata_i[1]));
endmodule

// File: rtl/pwm_dac_cnt.sv
module pwm_dac_cnt
  import pwm_dac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] ld_val_i,
  output logic [DATA_W-1:0] cnt_o
);
  logic [DATA_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R3
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_o == '0);
  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !ld_i |=> cnt_o == DATA_W'($past(cnt_o) + 1'b1));
endmodule

// File: rtl/pwm_dac_wave.sv
module pwm_dac_wave
  import pwm_dac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cfs_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic              pwm_o
);
  logic [DATA_W-1:0]    sh_d;
  logic                 sh_cfs;
  logic [N_CARRIER-1:0] hi_s, last_s, valid_s;
  logic                 out_q;

  for (genvar v = 0; v < N_CARRIER; v++) begin : g_car
    localparam int FW = (v == 0) ? FINE_W_FAST : FINE_W_SLOW;
    localparam int PW = DATA_W - FW;
    logic [PW-1:0] pos, coarse;
    logic [FW-1:0] idx, rev, fine;
    logic          extra;

    assign pos    = cnt_i[PW-1:0];
    assign idx    = cnt_i[DATA_W-1:PW];
    assign coarse = sh_d[DATA_W-1:FW];
    assign fine   = sh_d[FW-1:0];
    for (genvar b = 0; b < FW; b++) begin : g_rev
      assign rev[b] = idx[FW-1-b];
    end
    assign extra      = rev < fine;
    assign hi_s[v]    = (pos < coarse) || ((pos == coarse) && extra);
    assign last_s[v]  = &pos;
    assign valid_s[v] = |coarse;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_d   <= '1;
      sh_cfs <= 1'b1;
      out_q  <= 1'b0;
    end else begin
      if (!en_i || last_s[sh_cfs]) begin
        sh_d   <= data_i;
        sh_cfs <= cfs_i;
      end
      out_q <= en_i && valid_s[sh_cfs] && hi_s[sh_cfs];
    end
  end

  assign pwm_o = out_q;

  // R9
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);
  // R7
  range_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_s[sh_cfs] |=> !pwm_o);
  // R8
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !last_s[sh_cfs] |=> $stable(sh_d) && $stable(sh_cfs));
endmodule

// File: rtl/pwm_dac14.sv
module pwm_dac14
  import pwm_dac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             pwm_o
);
  logic [DATA_W-1:0] data, cnt;
  logic cfs, en, cnt_ld;

  pwm_dac_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .rdata_o, .data_o(data), .cfs_o(cfs),
    .en_o(en), .cnt_ld_o(cnt_ld)
  );

  pwm_dac_cnt u_cnt (
    .clk_i, .rst_ni, .en_i(en), .ld_i(cnt_ld),
    .ld_val_i(wdata_i[DATA_W-1:0]), .cnt_o(cnt)
  );

  pwm_dac_wave u_wave (
    .clk_i, .rst_ni, .en_i(en), .data_i(data), .cfs_i(cfs),
    .cnt_i(cnt), .pwm_o
  );
endmodule

// File: tb/pwm_dac14_test.sv
module pwm_dac14_test;
  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic pwm;
  int n_run = 0, n_fail = 0;
  logic [13:0] cur_d = 14'h3FFF;
  logic cur_cfs = 1'b1, cur_regs = 1'b1, cur_en = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dac14 uut (.clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr),
                 .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm));

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic write_data(input logic [13:0] d, input logic c);
    if (cur_regs) begin bus_wr(1'b0, {14'd0, cur_en, 1'b0}); cur_regs = 1'b0; end
    bus_wr(1'b0, {d, c, 1'b0});
    cur_d = d; cur_cfs = c;
  endtask

  task automatic write_ctrl(input logic e);
    if (!cur_regs) begin bus_wr(1'b0, {cur_d, cur_cfs, 1'b1}); cur_regs = 1'b1; end
    bus_wr(1'b0, {14'd0, e, 1'b1});
    cur_en = e;
  endtask

  task automatic measure(input int n, output int hi);
    hi = 0;
    repeat (n) begin @(negedge clk); hi += int'(pwm); end
  endtask

  task automatic integrate(input string tag, input logic [13:0] d, input logic c, input int exp);
    int hi;
    write_ctrl(1'b0);
    write_data(d, c);
    write_ctrl(1'b1);
    repeat (2) @(negedge clk);
    measure(16384, hi);
    chk(tag, hi, exp);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] r, r2;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, control view at address 0
    bus_rd(1'b0, r); chk("R1 ctrl view", r, 16'h0001);
    bus_rd(1'b1, r); chk("R1 counter", r, 0);
    chk("R1 pwm low", int'(pwm), 0);
    // R10 / R2 switch to data view: data reads back reset ones with select 0
    bus_wr(1'b0, 16'h0000); cur_regs = 1'b0;
    bus_rd(1'b0, r); chk("R10 data view", r, 16'hFFFE);
    bus_rd(1'b1, r); chk("R2 aux reset", r, 16'hFFFF);
    bus_wr(1'b1, 16'h1234);
    bus_rd(1'b1, r); chk("R2 aux rw", r, 16'h1234);
    write_data(14'h1235, 1'b0);
    bus_rd(1'b0, r); chk("R10 data fields", r, {14'h1235, 1'b0, 1'b0});

    // R9 disabled output stays low
    measure(100, hi); chk("R9 idle low", hi, 0);

    // R3 counter run, load, wrap, idle
    write_ctrl(1'b1);
    bus_rd(1'b1, r); @(negedge clk); bus_rd(1'b1, r2);
    chk("R3 step", r2, 16'(r + 1));
    bus_wr(1'b1, 16'h3FFE);
    bus_rd(1'b1, r); chk("R3 load", r, 16'h3FFE);
    @(negedge clk); bus_rd(1'b1, r); chk("R3 top", r, 16'h3FFF);
    @(negedge clk); bus_rd(1'b1, r); chk("R3 wrap", r, 0);
    bus_rd(1'b0, r); chk("R10 ctrl fields", r, 16'h0003);
    write_ctrl(1'b0);
    @(negedge clk); bus_rd(1'b1, r); chk("R3 idle zero", r, 0);
    bus_wr(1'b1, 16'h0123);
    bus_rd(1'b1, r); chk("R3 idle write ignored", r, 0);

    // R4 coarse sweep, 64-clock base, fine 0
    write_ctrl(1'b1);
    for (int c = 1; c < 64; c++) begin
      write_data(14'(c << 8), 1'b0);
      repeat (130) @(negedge clk);
      measure(64, hi); chk($sformatf("R4 coarse %0d", c), hi, c);
    end
    // R5 coarse sweep, 256-clock base, fine 0
    for (int c = 1; c < 256; c += 18) begin
      write_data(14'(c << 6), 1'b1);
      repeat (520) @(negedge clk);
      measure(256, hi); chk($sformatf("R5 coarse %0d", c), hi, c);
    end

    // R8 mid-cycle rewrite: coarse 10 -> 40 at position 20
    write_ctrl(1'b0);
    write_data(14'(10 << 8), 1'b0);
    write_ctrl(1'b1);
    do begin @(negedge clk); bus_rd(1'b1, r); end while (r[5:0] != 6'd19);
    bus_wr(1'b0, {14'd0, 1'b1, 1'b0}); cur_regs = 1'b0;
    bus_wr(1'b0, {14'(40 << 8), 1'b0, 1'b0}); cur_d = 14'(40 << 8); cur_cfs = 1'b0;
    hi = int'(pwm);
    repeat (43) begin @(negedge clk); hi += int'(pwm); end
    chk("R8 old cycle tail", hi, 0);
    measure(64, hi); chk("R8 new cycle width", hi, 40);

    // R6 full-period integration, R7 out of range
    integrate("R6 fast min", 14'h0100, 1'b0, 14'h0100);
    integrate("R6 fast max", 14'h3FFF, 1'b0, 14'h3FFF);
    integrate("R6 fast mid", 14'h1235, 1'b0, 14'h1235);
    integrate("R6 slow min", 14'h0040, 1'b1, 14'h0040);
    integrate("R6 slow mid", 14'h2A7B, 1'b1, 14'h2A7B);
    integrate("R7 fast below", 14'h00FF, 1'b0, 0);
    integrate("R7 slow below", 14'h003F, 1'b1, 0);

    summary();
  end
endmodule